// File: doc/BRIEF.md
# Conditional Branch and Set Evaluator

This block decides whether a flag condition holds and turns that decision into either a new instruction pointer or a one-bit byte result. The low four bits of an opcode choose the condition. Bits 3:1 pick one of eight predicates over the overflow, carry, zero, sign and parity flags, and bit 0 inverts the choice. The high four bits of the opcode must match the group that fits the selected mode, or the block flags the opcode as illegal.

In branch mode, a displacement is added to the incoming instruction pointer when the condition holds. The incoming pointer already points past the displacement bytes. The displacement is either the full 32-bit value or its low 16 bits sign-extended, depending on the operand-size input. In set mode the pointer passes through unchanged, and the result byte is 1 or 0. The displacement is fetched elsewhere and arrives here as a plain input.

The outputs go through one register stage when `REG_OUT` is nonzero, which is the default. With `REG_OUT` at zero the block is purely combinational.

Top module: `cond_branch_eval`

## Requirements
- R1: Opcode bits 3:1 select the predicate: code 0 is OF, 1 is CF, 2 is ZF, 3 is CF or ZF, 4 is SF, 5 is PF, 6 is SF xor OF, and 7 is (SF xor OF) or ZF.
- R2: When opcode bit 0 is 1, the selected predicate is inverted before it is used.
- R3: When `wide_op` is 0, the displacement used is `disp[15:0]` sign-extended to 32 bits. When `wide_op` is 1, all 32 bits of `disp` are used.
- R4: In branch mode with a legal opcode and a condition that holds, `ip_next` equals `ip_in + displacement` modulo 2^32. In every other case `ip_next` equals `ip_in`.
- R5: In set mode `set_byte` is 1 when the condition holds and 0 otherwise. In branch mode `set_byte` is 0.
- R6: Branch mode (`set_mode`=0) requires opcode bits 7:4 to be 0x8, and set mode (`set_mode`=1) requires 0x9. On a mismatch `illegal` is 1, `taken` is 0, `set_byte` is 0 and `ip_next` equals `ip_in`.
- R7: `taken` is 1 exactly when the opcode is legal and the condition holds, in either mode.
- R8: With `REG_OUT`=1, every output reflects the inputs of the previous rising clock edge. While `rst_n` is low, all outputs are 0.
- R9: When `wide_op` is 0, bits 31:16 of `disp` have no effect on `ip_next`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 8 | Opcode byte: group in bits 7:4, condition in bits 3:0 |
| set_mode | input | 1 | 0 selects branch, 1 selects set |
| wide_op | input | 1 | 1 selects a 32-bit displacement, 0 selects a 16-bit one |
| disp | input | 32 | Branch displacement |
| ip_in | input | 32 | Address following the displacement |
| flag_of | input | 1 | Overflow flag |
| flag_cf | input | 1 | Carry flag |
| flag_zf | input | 1 | Zero flag |
| flag_sf | input | 1 | Sign flag |
| flag_pf | input | 1 | Parity flag |
| ip_next | output | 32 | Next instruction pointer |
| taken | output | 1 | Condition held for a legal opcode |
| set_byte | output | 8 | Set-mode result, 0 or 1 |
| illegal | output | 1 | Opcode group does not match the mode |

## Verification
With the default output register, all four results (`ip_next`, `taken`, `set_byte` and `illegal`) are due on the first rising edge after the inputs are applied, and they hold until the next edge. The driver applies inputs on a falling edge and tags each expected item with the clock count at which it becomes due. The monitor compares an item only on the falling edge after that count is reached, so every comparison falls half a period after the register updates. The checker delays `ip_in` and `set_mode` by the same one stage before relating them to the outputs.

// File: rtl/cc_eval_pkg.sv
package cc_eval_pkg;
  typedef struct packed {
    logic of_f;
    logic cf_f;
    logic zf_f;
    logic sf_f;
    logic pf_f;
  } cc_flags_t;

  localparam logic [3:0] GRP_BRANCH = 4'h8;
  localparam logic [3:0] GRP_SET    = 4'h9;
endpackage

// File: rtl/cc_pred.sv
module cc_pred
  import cc_eval_pkg::*;
(
  input  cc_flags_t  flags,
  input  logic [2:0] sel,
  input  logic       inv,
  output logic       hold
);
  logic raw;
  logic lt;

  assign lt = flags.sf_f ^ flags.of_f;

  always_comb begin
    case (sel)
      3'd0:    raw = flags.of_f;
      3'd1:    raw = flags.cf_f;
      3'd2:    raw = flags.zf_f;
      3'd3:    raw = flags.cf_f | flags.zf_f;
      3'd4:    raw = flags.sf_f;
      3'd5:    raw = flags.pf_f;
      3'd6:    raw = lt;
      default: raw = lt | flags.zf_f;
    endcase
  end

  assign hold = raw ^ inv;
endmodule

// File: rtl/cc_disp_ext.sv
module cc_disp_ext #(
  parameter int ADDR_W  = 32,
  parameter int SHORT_W = 16
) (
  input  logic [ADDR_W-1:0] disp,
  input  logic              wide,
  output logic [ADDR_W-1:0] disp_x
);
  localparam int EXT_W = ADDR_W - SHORT_W;

  logic [ADDR_W-1:0] short_x;

  assign short_x = {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
  assign disp_x  = wide ? disp : short_x;
endmodule

// File: rtl/cc_out_stage.sv
module cc_out_stage #(
  parameter int ADDR_W  = 32,
  parameter int RES_W   = 8,
  parameter int REG_OUT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ip_d,
  input  logic              taken_d,
  input  logic [RES_W-1:0]  sb_d,
  input  logic              ill_d,
  output logic [ADDR_W-1:0] ip_q,
  output logic              taken_q,
  output logic [RES_W-1:0]  sb_q,
  output logic              ill_q
);
  generate
    if (REG_OUT != 0) begin : g_reg
      logic [ADDR_W-1:0] ip_r,    ip_nx;
      logic              taken_r, taken_nx;
      logic [RES_W-1:0]  sb_r,    sb_nx;
      logic              ill_r,   ill_nx;

      always_comb begin
        ip_nx    = ip_d;
        taken_nx = taken_d;
        sb_nx    = sb_d;
        ill_nx   = ill_d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ip_r    <= '0;
          taken_r <= 1'b0;
          sb_r    <= '0;
          ill_r   <= 1'b0;
        end else begin
          ip_r    <= ip_nx;
          taken_r <= taken_nx;
          sb_r    <= sb_nx;
          ill_r   <= ill_nx;
        end
      end

      assign ip_q    = ip_r;
      assign taken_q = taken_r;
      assign sb_q    = sb_r;
      assign ill_q   = ill_r;
    end else begin : g_comb
      logic unused_ok;
      assign unused_ok = clk ^ rst_n;
      assign ip_q    = ip_d;
      assign taken_q = taken_d;
      assign sb_q    = sb_d;
      assign ill_q   = ill_d;
    end
  endgenerate
endmodule

// File: rtl/cond_branch_eval.sv
module cond_branch_eval
  import cc_eval_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SHORT_W = 16,
  parameter int RES_W   = 8,
  parameter int REG_OUT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        opcode,
  input  logic              set_mode,
  input  logic              wide_op,
  input  logic [ADDR_W-1:0] disp,
  input  logic [ADDR_W-1:0] ip_in,
  input  logic              flag_of,
  input  logic              flag_cf,
  input  logic              flag_zf,
  input  logic              flag_sf,
  input  logic              flag_pf,
  output logic [ADDR_W-1:0] ip_next,
  output logic              taken,
  output logic [RES_W-1:0]  set_byte,
  output logic              illegal
);
  cc_flags_t         flags;
  logic              hold;
  logic              legal;
  logic              taken_d;
  logic [ADDR_W-1:0] disp_x;
  logic [ADDR_W-1:0] ip_d;
  logic [RES_W-1:0]  sb_d;

  assign flags = '{of_f: flag_of, cf_f: flag_cf, zf_f: flag_zf,
                   sf_f: flag_sf, pf_f: flag_pf};

  cc_pred u_pred (
    .flags (flags),
    .sel   (opcode[3:1]),
    .inv   (opcode[0]),
    .hold  (hold)
  );

  cc_disp_ext #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_ext (
    .disp   (disp),
    .wide   (wide_op),
    .disp_x (disp_x)
  );

  always_comb begin
    legal   = set_mode ? (opcode[7:4] == GRP_SET) : (opcode[7:4] == GRP_BRANCH);
    taken_d = legal & hold;
    ip_d    = (!set_mode && taken_d) ? (ip_in + disp_x) : ip_in;
    sb_d    = '0;
    sb_d[0] = set_mode & taken_d;
  end

  cc_out_stage #(.ADDR_W(ADDR_W), .RES_W(RES_W), .REG_OUT(REG_OUT)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .ip_d    (ip_d),
    .taken_d (taken_d),
    .sb_d    (sb_d),
    .ill_d   (~legal),
    .ip_q    (ip_next),
    .taken_q (taken),
    .sb_q    (set_byte),
    .ill_q   (illegal)
  );
endmodule

// File: rtl/cc_eval_chk.sv
module cc_eval_chk #(
  parameter int ADDR_W  = 32,
  parameter int RES_W   = 8,
  parameter int REG_OUT = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              set_mode,
  input logic [ADDR_W-1:0] ip_in,
  input logic [ADDR_W-1:0] ip_next,
  input logic              taken,
  input logic [RES_W-1:0]  set_byte,
  input logic              illegal
);
  logic [ADDR_W-1:0] d_ip;
  logic              d_set;
  logic              d_live;

  generate
    if (REG_OUT != 0) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          d_ip   <= '0;
          d_set  <= 1'b0;
          d_live <= 1'b0;
        end else begin
          d_ip   <= ip_in;
          d_set  <= set_mode;
          d_live <= 1'b1;
        end
      end
    end else begin : g_nodly
      assign d_ip   = ip_in;
      assign d_set  = set_mode;
      assign d_live = rst_n;
    end
  endgenerate

  // R6
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_live && illegal) |-> (!taken && set_byte == '0 && ip_next == d_ip));

  // R4
  hold_ip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_live && !taken) |-> (ip_next == d_ip));

  // R5
  set_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_live |-> (set_byte[RES_W-1:1] == '0));

  // R5
  set_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_live && d_set) |-> (set_byte[0] == taken && ip_next == d_ip));

  // R5
  branch_byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_live && !d_set) |-> (set_byte == '0));

  // R7
  taken_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_live |-> !(taken && illegal));
endmodule

bind cond_branch_eval cc_eval_chk #(
  .ADDR_W(ADDR_W), .RES_W(RES_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .set_mode (set_mode),
  .ip_in    (ip_in),
  .ip_next  (ip_next),
  .taken    (taken),
  .set_byte (set_byte),
  .illegal  (illegal)
);

// File: tb/sim_cond_branch_eval.sv
`timescale 1ns/1ps
module sim_cond_branch_eval;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  opcode;
  logic        set_mode, wide_op;
  logic [31:0] disp, ip_in;
  logic        f_of, f_cf, f_zf, f_sf, f_pf;
  logic [31:0] ip_next;
  logic        taken, illegal;
  logic [7:0]  set_byte;

  typedef struct {
    int          due;
    logic [31:0] ip;
    logic        tk;
    logic [7:0]  sb;
    logic        ill;
    string       req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cond_branch_eval u0 (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .set_mode(set_mode),
    .wide_op(wide_op), .disp(disp), .ip_in(ip_in),
    .flag_of(f_of), .flag_cf(f_cf), .flag_zf(f_zf), .flag_sf(f_sf), .flag_pf(f_pf),
    .ip_next(ip_next), .taken(taken), .set_byte(set_byte), .illegal(illegal)
  );

  // flags vector order: {of, cf, zf, sf, pf}
  function automatic logic cond_ref(logic [3:0] nib, logic [4:0] fl);
    logic o, c, z, s, p, r;
    {o, c, z, s, p} = fl;
    case (nib[3:1])
      3'd0: r = o;
      3'd1: r = c;
      3'd2: r = z;
      3'd3: r = c || z;
      3'd4: r = s;
      3'd5: r = p;
      3'd6: r = (s != o);
      default: r = (s != o) || z;
    endcase
    return nib[0] ? !r : r;
  endfunction

  task automatic drive(input logic [7:0] op, input logic sm, input logic w,
                       input logic [31:0] d, input logic [31:0] ip,
                       input logic [4:0] fl, input string req);
    exp_t e;
    logic lg, c;
    logic [31:0] dx;
    @(negedge clk);
    opcode = op; set_mode = sm; wide_op = w; disp = d; ip_in = ip;
    {f_of, f_cf, f_zf, f_sf, f_pf} = fl;
    lg = sm ? (op[7:4] == 4'h9) : (op[7:4] == 4'h8);
    c  = lg && cond_ref(op[3:0], fl);
    dx = w ? d : {{16{d[15]}}, d[15:0]};
    e.due = cyc + 1;
    e.ip  = (!sm && c) ? ip + dx : ip;
    e.tk  = c;
    e.sb  = {7'd0, sm && c};
    e.ill = !lg;
    e.req = req;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due <= cyc) begin
        e = q.pop_front();
        n_chk++;
        if (ip_next !== e.ip || taken !== e.tk || set_byte !== e.sb || illegal !== e.ill) begin
          n_bad++;
          $display("FAIL %s: got ip=%h tk=%b sb=%h ill=%b exp ip=%h tk=%b sb=%h ill=%b",
                   e.req, ip_next, taken, set_byte, illegal, e.ip, e.tk, e.sb, e.ill);
        end
      end
    end
  end

  initial begin : watchdog
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang exp finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0;
    opcode = 8'h80; set_mode = 0; wide_op = 1; disp = 0; ip_in = 0;
    {f_of, f_cf, f_zf, f_sf, f_pf} = 5'b0;
    repeat (3) @(negedge clk);
    // R8 reset state
    n_chk++;
    if (ip_next !== 0 || taken !== 0 || set_byte !== 0 || illegal !== 0) begin
      n_bad++;
      $display("FAIL R8: got ip=%h tk=%b sb=%h ill=%b exp all zero", ip_next, taken, set_byte, illegal);
    end
    rst_n = 1'b1;

    // R1 branch sweep over every condition and flag pattern
    for (int n = 0; n < 16; n++)
      for (int f = 0; f < 32; f++)
        drive({4'h8, 4'(n)}, 1'b0, 1'b1, 32'h0000_0100, 32'h0000_4000, 5'(f), "R1");
    // R5 set sweep
    for (int n = 0; n < 16; n++)
      for (int f = 0; f < 32; f += 3)
        drive({4'h9, 4'(n)}, 1'b1, 1'b1, 32'h0000_0100, 32'h0000_4000, 5'(f), "R5");
    // R2 inversion pairs: ZF set, codes 2 and 3 of bit0
    drive(8'h84, 1'b0, 1'b1, 32'h10, 32'h1000, 5'b00100, "R2");
    drive(8'h85, 1'b0, 1'b1, 32'h10, 32'h1000, 5'b00100, "R2");
    drive(8'h9E, 1'b1, 1'b1, 32'h0, 32'h2000, 5'b10000, "R2");
    drive(8'h9F, 1'b1, 1'b1, 32'h0, 32'h2000, 5'b10000, "R2");
    // R3 short negative displacement
    drive(8'h81, 1'b0, 1'b0, 32'h0000_FFFE, 32'h0000_1000, 5'b0, "R3");
    drive(8'h81, 1'b0, 1'b0, 32'h0000_7FFF, 32'h0000_1000, 5'b0, "R3");
    drive(8'h81, 1'b0, 1'b1, 32'h8000_0000, 32'h0000_1000, 5'b0, "R3");
    // R9 upper bits ignored in short mode
    drive(8'h81, 1'b0, 1'b0, 32'hABCD_0010, 32'h0000_1000, 5'b0, "R9");
    drive(8'h81, 1'b0, 1'b0, 32'h1234_8000, 32'h0000_1000, 5'b0, "R9");
    // R4 wrap modulo 2^32 and not-taken hold
    drive(8'h81, 1'b0, 1'b1, 32'h0000_0020, 32'hFFFF_FFF0, 5'b0, "R4");
    drive(8'h80, 1'b0, 1'b1, 32'h0000_0020, 32'hFFFF_FFF0, 5'b0, "R4");
    drive(8'h81, 1'b0, 1'b0, 32'h0000_8000, 32'h0000_0010, 5'b0, "R4");
    // R6 group mismatch in both modes
    drive(8'h91, 1'b0, 1'b1, 32'h40, 32'h3000, 5'b0, "R6");
    drive(8'h81, 1'b1, 1'b1, 32'h40, 32'h3000, 5'b0, "R6");
    drive(8'h01, 1'b0, 1'b1, 32'h40, 32'h3000, 5'b0, "R6");
    drive(8'hF1, 1'b1, 1'b0, 32'h40, 32'h3000, 5'b0, "R6");
    // R7 taken in set mode with legal and illegal groups
    drive(8'h93, 1'b1, 1'b1, 32'h0, 32'h5000, 5'b01000, "R7");
    drive(8'h83, 1'b1, 1'b1, 32'h0, 32'h5000, 5'b01000, "R7");
    // R8 back-to-back one-cycle latency
    drive(8'h8E, 1'b0, 1'b1, 32'h8, 32'h100, 5'b00000, "R8");
    drive(8'h8F, 1'b0, 1'b1, 32'h8, 32'h200, 5'b00000, "R8");

    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule